// File: doc/BRIEF.md
# Eight-Channel Start-Stop Time Digitizer

This block measures, for each of eight channels, how long after a shared start pulse that channel's own stop pulse arrived. The interval is counted in cycles of the block's clock. A single start latch opens counting on every channel at once. Each channel then freezes its own counter when its stop pulse shows up, so after one event the eight counters hold eight separate intervals, all measured from the same start. At a 50 MHz clock, one count is 20 ns and the 12-bit range covers about 82 us.

Software drives the block through a four-word register port selected by a 2-bit address:
- A write to the arm address clears every counter and flag and arms the unit.
- Software then polls the trigger-status bit until the start has been seen.
- A write to the load address copies all live counters into holding registers.
- Each channel is then read in turn: write its number to the select address, then read the data word.

The start and stop inputs are asynchronous. Each one passes through a synchronizer and a rising-edge detector before it reaches the latches.

Top module: `drift_tdc`

## Requirements
- R1: After reset the unit is disarmed, the trigger latch is clear, all counters and holding registers are zero, and `host_rdata` is zero.
- R2: A write to address 0 clears every live counter, stop flag, overflow flag, holding register and the trigger latch, and arms the unit. A read after a fresh arm and load returns 0x0000 for any channel.
- R3: A rising start edge sets the trigger latch only while the unit is armed. The latch's state appears in read-word bit 15 and stays set until the next arm write. A start edge while disarmed leaves bit 15 at 0.
- R4: A channel whose stop input rises n clock cycles after the start input rises (n ≥ 0) holds the count n. Its count does not change after that.
- R5: Stop edges are ignored before the start and while the unit is disarmed. After the start, only the first stop edge on a channel takes effect. Read-word bit 14 shows that the selected channel has stopped.
- R6: A running counter stops at 4095 and does not wrap. Reaching 4095 sets that channel's overflow flag, shown in read-word bit 13.
- R7: A write to address 1 selects the channel given by `host_wdata[2:0]`. All higher data bits are ignored.
- R8: A write to address 3 copies every live count and flag into holding registers, and reads return only the holding copy. A channel still running when the load is written m cycles after the start rises (m ≥ 3) holds the count m−3, and that held value does not change until the next load.
- R9: A read (`host_rd` with address 2) presents the word {trigger, stopped, overflow, 0, count[11:0]} (bits 15, 14, 13, 12, 11:0) on `host_rdata` in the next cycle. `host_rdata` holds its value at all other times.
- R10: A stop that rises in the same cycle as the start yields the count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and port clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Asynchronous common start pulse |
| stop_in | input | 8 | Asynchronous per-channel stop pulses |
| host_addr | input | 2 | Register address: 0 arm, 1 select, 2 read, 3 load |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Registered read word |

## Verification
Some properties are checked by assertions on every cycle:
- The trigger latch stays set once it is set, and cannot be set while the unit is disarmed.
- A stopped channel keeps its count frozen.
- An idle channel's count does not move.
- A saturated counter stays at 4095.
- An arm write zeroes the channel state.
- The read word changes only on a read.

Only the bench's scenarios can show the other properties:
- A stop n cycles after the start yields exactly n, including n = 0.
- An early stop pulse and a second stop pulse leave the count unchanged.
- A mid-run snapshot holds m−3 while the live counter moves on.
- The high select bits are ignored.

// File: rtl/drift_tdc_pkg.sv
package drift_tdc_pkg;
  typedef enum logic [1:0] {
    PORT_ARM  = 2'd0,
    PORT_SEL  = 2'd1,
    PORT_READ = 2'd2,
    PORT_LOAD = 2'd3
  } port_e;
endpackage

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             stop_en,
  input  logic             stop_rise,
  input  logic             load,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             hold_stp,
  output logic             hold_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             stp_q, ovf_q;
  logic             step;

  assign step = run && !stp_q && (cnt_q != CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      stp_q    <= 1'b0;
      ovf_q    <= 1'b0;
      hold_cnt <= '0;
      hold_stp <= 1'b0;
      hold_ovf <= 1'b0;
    end else begin
      if (stop_en && stop_rise) stp_q <= 1'b1;
      if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_MAX - 1'b1) ovf_q <= 1'b1;
      end
      if (load) begin
        hold_cnt <= cnt_q;
        hold_stp <= stp_q;
        hold_ovf <= ovf_q;
      end
    end
  end

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stp_q && !clr) |=> stp_q); // R5
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (stp_q && !clr) |=> $stable(cnt_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt_q)); // R4
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX && ovf_q)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && !stp_q && !ovf_q && hold_cnt == '0)); // R2
endmodule

// File: rtl/drift_tdc.sv
module drift_tdc #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_in,
  input  logic [NUM_CH-1:0] stop_in,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata
);
  import drift_tdc_pkg::*;

  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BIT_TRIG = DATA_W - 1;
  localparam int BIT_STP  = DATA_W - 2;
  localparam int BIT_OVF  = DATA_W - 3;

  logic              arm_wr, sel_wr, load_wr, read_req;
  logic              armed_q, master_q;
  logic [SEL_W-1:0]  sel_q;
  logic              start_rise, start_fire;
  logic [NUM_CH-1:0] stop_rise;
  logic [CNT_W-1:0]  h_cnt [NUM_CH];
  logic [NUM_CH-1:0] h_stp, h_ovf;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign unused_wdata = ^host_wdata[DATA_W-1:SEL_W];

  assign arm_wr   = host_wr && (host_addr == PORT_ARM);
  assign sel_wr   = host_wr && (host_addr == PORT_SEL);
  assign load_wr  = host_wr && (host_addr == PORT_LOAD);
  assign read_req = host_rd && (host_addr == PORT_READ);

  tdc_edge_sync #(.W(1)) u_start_sync (
    .clk(clk), .rst(rst), .async_in(start_in), .rise(start_rise)
  );

  tdc_edge_sync #(.W(NUM_CH)) u_stop_sync (
    .clk(clk), .rst(rst), .async_in(stop_in), .rise(stop_rise)
  );

  assign start_fire = start_rise && armed_q && !master_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      master_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      if (arm_wr) begin
        armed_q  <= 1'b1;
        master_q <= 1'b0;
      end else if (start_fire) begin
        master_q <= 1'b1;
      end
      if (sel_wr) sel_q <= host_wdata[SEL_W-1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    tdc_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .clr      (arm_wr),
      .run      (master_q),
      .stop_en  (master_q || start_fire),
      .stop_rise(stop_rise[ch]),
      .load     (load_wr),
      .hold_cnt (h_cnt[ch]),
      .hold_stp (h_stp[ch]),
      .hold_ovf (h_ovf[ch])
    );
  end

  always_comb begin
    rd_word           = '0;
    rd_word[BIT_TRIG] = master_q;
    if (int'(sel_q) < NUM_CH) begin
      rd_word[BIT_STP]     = h_stp[sel_q];
      rd_word[BIT_OVF]     = h_ovf[sel_q];
      rd_word[CNT_W-1:0]   = h_cnt[sel_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (read_req) host_rdata <= rd_word;
  end

  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (master_q && !arm_wr) |=> master_q); // R3
  AST_DISARMED_NO_TRIG: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !arm_wr) |=> !master_q); // R3
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm_wr |=> (armed_q && !master_q)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !read_req |=> $stable(host_rdata)); // R9
endmodule

// File: tb/drift_tdc_test.sv
`timescale 1ns/1ps
module drift_tdc_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_in;
  logic [7:0]  stop_in;
  logic [1:0]  host_addr;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;

  int tests = 0;
  int fails = 0;
  int dly [8] = '{0, 1, 5, 37, 100, 255, 1000, -1};
  logic [15:0] exp_w, last_w;

  always #4 clk = ~clk;

  drift_tdc uut (
    .clk(clk), .rst(rst), .start_in(start_in), .stop_in(stop_in),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d);
    host_addr = 2'd2; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    rst = 1'b1; start_in = 1'b0; stop_in = '0;
    host_addr = '0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rdata", host_rdata, 16'h0000);
    rd(w);
    chk("R1 reset read word", w, 16'h0000);

    // R3: start while disarmed is ignored
    start_in = 1'b1;
    repeat (6) @(negedge clk);
    start_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(w);
    chk("R3 disarmed start ignored", w, 16'h0000);

    wr(2'd0, 16'h0000);

    for (int k = 0; k <= 4300; k++) begin
      if (k == 0) stop_in[2] = 1'b1;       // R5 early stop before start
      if (k == 4) stop_in[2] = 1'b0;
      if (k == 10) start_in = 1'b1;
      if (k == 60) start_in = 1'b0;
      for (int i = 0; i < 8; i++)
        if (dly[i] >= 0 && k == 10 + dly[i]) stop_in[i] = 1'b1;
      if (k == 19) stop_in[1] = 1'b0;      // R5 second stop edge
      if (k == 23) stop_in[1] = 1'b1;
      case (k)
        340: begin host_addr = 2'd1; host_wdata = 16'd6; host_wr = 1'b1; end
        341: host_wr = 1'b0;
        350: begin host_addr = 2'd3; host_wr = 1'b1; end
        351: host_wr = 1'b0;
        352: begin host_addr = 2'd2; host_rd = 1'b1; end
        353: begin
          host_rd = 1'b0;
          chk("R8 mid-run snapshot m-3", host_rdata, 16'h8000 | 16'(350 - 10 - 3));
        end
        400: begin host_addr = 2'd2; host_rd = 1'b1; end
        401: begin
          host_rd = 1'b0;
          chk("R8 holding stays while live counts", host_rdata, 16'h8000 | 16'(337));
        end
        default: ;
      endcase
      @(negedge clk);
    end
    stop_in = '0;
    repeat (4) @(negedge clk);

    wr(2'd3, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, 16'hFFF8 | 16'(i));
      rd(w);
      if (dly[i] >= 0) exp_w = 16'hC000 | 16'(dly[i]);
      else             exp_w = 16'hA000 | 16'd4095;
      case (i)
        0: chk("R10 stop with start gives 0", w, exp_w);
        1: chk("R5 second stop ignored", w, exp_w);
        2: chk("R5 early stop ignored", w, exp_w);
        7: chk("R6 saturation and overflow", w, exp_w);
        default: chk("R4 R7 interval count", w, exp_w);
      endcase
      last_w = w;
    end

    wr(2'd1, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R9 rdata holds without read", host_rdata, last_w);

    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0003);
    rd(w);
    chk("R2 arm clears all state", w, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule